// File: doc/BRIEF.md
# Interrupt Entry Machine-State Updater

This block applies the side effects of interrupt entry to the machine state of a small processor core. It holds a 32-bit implementation control word that software reads and writes. It also holds the three interrupt enable bits of the machine state (external, critical, debug), the load-reserve reservation flag and the debug-enable copy that is saved for a debug return.

Five one-cycle entry strobes arrive from the exception sequencer: external input, critical input, watchdog, machine check and debug. When several strobes coincide, only the highest-priority one takes effect. The control word decides which enable bits and whether the reservation that entry clears. A critical-class or machine-check entry that occurs while debug is enabled and critical-interrupt debug events are allowed raises a deferred debug event, and forces the saved debug-enable copy to zero.

The control word also gates the timebase increment.

Top module: `irq_entry_top`

## Requirements
- R1: After reset, cfgRdData is 0, all three enables are 0, resvValid is 0, savedDbgEn is 0, dbgEvtPend is 0 and tbIncEn is 0.
- R2: The control word uses big-endian numbering, where bit n is cfgRdData[31-n]. Only bits 14, 15, 17, 19, 20, 21 and 22 are implemented, so a write of all ones reads back 0x00035E00. Every other bit, including the reserved bits 16 and 18, reads zero.
- R3: Bit 15 (cfgRdData[16]) is a software flag. Writing 1 sets it, writing 0 leaves it unchanged, and only reset clears it.
- R4: tbIncEn equals tbTick AND bit 17 (cfgRdData[14]).
- R5: With bit 14 set, external and critical input entry clear resvValid. Watchdog, machine-check and debug entry never clear it. With bit 14 clear, no entry touches it. resvSet sets resvValid.
- R6: Debug entry clears extEnable when bit 19 is set, and clears critEnable when bit 20 is set.
- R7: Critical input and watchdog entry clear dbgEnable when bit 21 is set. Bit 21 has no effect on machine-check entry.
- R8: Machine-check entry clears dbgEnable when bit 22 is set.
- R9: A critical input, watchdog or machine-check entry with critDbgEvtEn=1 and dbgEnable=1 pulses dbgEvtPend for one cycle after the entry edge, and sets savedDbgEn to 0.
- R10: Debug entry copies the pre-entry dbgEnable into savedDbgEn.
- R11: Of coincident strobes only one is applied, in the priority order machine check, debug, critical/watchdog, external.
- R12: A control or machine-state write in the same cycle as a strobe is applied before the strobe's effects. An entry clear wins over a same-cycle resvSet. All state changes appear at the clock edge after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write data |
| cfgRdData | output | 32 | Control word read data |
| msrWrEn | input | 1 | Machine-state enable write strobe |
| msrWrData | input | 3 | Enables to write: [2] external, [1] critical, [0] debug |
| extEnable | output | 1 | External interrupt enable |
| critEnable | output | 1 | Critical interrupt enable |
| dbgEnable | output | 1 | Debug interrupt enable |
| resvSet | input | 1 | Load-reserve sets the reservation |
| resvValid | output | 1 | Reservation outstanding |
| irqExt | input | 1 | External input entry strobe |
| irqCrit | input | 1 | Critical input entry strobe |
| irqWdog | input | 1 | Watchdog entry strobe |
| irqMchk | input | 1 | Machine-check entry strobe |
| irqDbg | input | 1 | Debug entry strobe |
| critDbgEvtEn | input | 1 | Critical-interrupt debug events allowed |
| tbTick | input | 1 | Raw timebase tick |
| tbIncEn | output | 1 | Gated timebase increment enable |
| dbgEvtPend | output | 1 | Deferred debug event pulse |
| savedDbgEn | output | 1 | Debug-enable copy saved for debug return |

## Verification
A wrong bit in the held control word shows up at cfgRdData on the next cycle. It shows up in the enable and reservation outputs one edge after the next strobe that the bit governs. A wrong priority or policy decision corrupts exactly one of extEnable, critEnable, dbgEnable or resvValid one edge after the strobe. A wrong deferred-event decision shows at dbgEvtPend and savedDbgEn on that same edge. The bench therefore compares every output after every single edge, which keeps the latency between a fault and its first visible symptom to one cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int CFG_W = 32;

  // big-endian bit numbers of the implemented control bits
  localparam int NUM_RESV_CLR  = 14;
  localparam int NUM_SW_FLAG   = 15;
  localparam int NUM_TB_EN     = 17;
  localparam int NUM_DBG_EE    = 19;
  localparam int NUM_DBG_CE    = 20;
  localparam int NUM_CRIT_DE   = 21;
  localparam int NUM_MCHK_DE   = 22;

  // vector indices derived from the numbering
  localparam int IDX_RESV_CLR = CFG_W - 1 - NUM_RESV_CLR;
  localparam int IDX_SW_FLAG  = CFG_W - 1 - NUM_SW_FLAG;
  localparam int IDX_TB_EN    = CFG_W - 1 - NUM_TB_EN;
  localparam int IDX_DBG_EE   = CFG_W - 1 - NUM_DBG_EE;
  localparam int IDX_DBG_CE   = CFG_W - 1 - NUM_DBG_CE;
  localparam int IDX_CRIT_DE  = CFG_W - 1 - NUM_CRIT_DE;
  localparam int IDX_MCHK_DE  = CFG_W - 1 - NUM_MCHK_DE;

  localparam logic [CFG_W-1:0] IMPL_MASK =
      (CFG_W'(1) << IDX_RESV_CLR) | (CFG_W'(1) << IDX_SW_FLAG) |
      (CFG_W'(1) << IDX_TB_EN)    | (CFG_W'(1) << IDX_DBG_EE)  |
      (CFG_W'(1) << IDX_DBG_CE)   | (CFG_W'(1) << IDX_CRIT_DE) |
      (CFG_W'(1) << IDX_MCHK_DE);

  typedef enum logic [2:0] {
    CLS_NONE, CLS_EXT, CLS_CRIT, CLS_WDOG, CLS_DBG, CLS_MCHK
  } irqClass_e;

  // policy bits the datapath hands to the control
  typedef struct packed {
    logic resvClr;
    logic dbgClrEE;
    logic dbgClrCE;
    logic critClrDE;
    logic mchkClrDE;
  } policy_t;

  // strobes the control hands to the datapath
  typedef struct packed {
    logic clrExtEn;
    logic clrCritEn;
    logic clrDbgEn;
    logic clrResv;
    logic saveDbgEn;
    logic zeroSavedDbgEn;
    logic raiseDbgEvt;
  } entryStrobe_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  policy_t      policy,
  input  logic         effDbgEn,
  input  logic         irqExt,
  input  logic         irqCrit,
  input  logic         irqWdog,
  input  logic         irqMchk,
  input  logic         irqDbg,
  input  logic         critDbgEvtEn,
  output entryStrobe_t strb
);

  irqClass_e cls;
  logic      critClass;

  // fixed priority: machine check, debug, critical/watchdog, external
  always_comb begin
    cls = CLS_NONE;
    if (irqMchk)      cls = CLS_MCHK;
    else if (irqDbg)  cls = CLS_DBG;
    else if (irqCrit) cls = CLS_CRIT;
    else if (irqWdog) cls = CLS_WDOG;
    else if (irqExt)  cls = CLS_EXT;
  end

  assign critClass = (cls == CLS_CRIT) || (cls == CLS_WDOG);

  always_comb begin
    strb = '0;
    unique case (cls)
      CLS_MCHK: begin
        strb.clrDbgEn = policy.mchkClrDE;
      end
      CLS_DBG: begin
        strb.clrExtEn  = policy.dbgClrEE;
        strb.clrCritEn = policy.dbgClrCE;
        strb.saveDbgEn = 1'b1;
      end
      CLS_CRIT: begin
        strb.clrDbgEn = policy.critClrDE;
        strb.clrResv  = policy.resvClr;
      end
      CLS_WDOG: begin
        strb.clrDbgEn = policy.critClrDE;
      end
      CLS_EXT: begin
        strb.clrResv = policy.resvClr;
      end
      default: ;
    endcase
    // deferred debug event on critical-class or machine-check entry
    if ((critClass || cls == CLS_MCHK) && critDbgEvtEn && effDbgEn) begin
      strb.raiseDbgEvt    = 1'b1;
      strb.zeroSavedDbgEn = 1'b1;
    end
  end

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             msrWrEn,
  input  logic [2:0]       msrWrData,
  input  logic             resvSet,
  input  logic             tbTick,
  input  entryStrobe_t     strb,
  output policy_t          policy,
  output logic             effDbgEn,
  output logic             extEnable,
  output logic             critEnable,
  output logic             dbgEnable,
  output logic             resvValid,
  output logic             tbIncEn,
  output logic             dbgEvtPend,
  output logic             savedDbgEn
);

  logic [CFG_W-1:0] cfgQ, cfgEff;
  logic eeQ, ceQ, deQ, resvQ, savedQ, evtQ;
  logic effEE, effCE, effResv;

  // same-cycle software write is folded in before the strobe is evaluated
  always_comb begin
    cfgEff = (cfgWrEn ? cfgWrData : cfgQ) & IMPL_MASK;
    cfgEff[IDX_SW_FLAG] = cfgQ[IDX_SW_FLAG] | (cfgWrEn & cfgWrData[IDX_SW_FLAG]);
  end

  assign policy.resvClr   = cfgEff[IDX_RESV_CLR];
  assign policy.dbgClrEE  = cfgEff[IDX_DBG_EE];
  assign policy.dbgClrCE  = cfgEff[IDX_DBG_CE];
  assign policy.critClrDE = cfgEff[IDX_CRIT_DE];
  assign policy.mchkClrDE = cfgEff[IDX_MCHK_DE];

  assign effEE    = msrWrEn ? msrWrData[2] : eeQ;
  assign effCE    = msrWrEn ? msrWrData[1] : ceQ;
  assign effDbgEn = msrWrEn ? msrWrData[0] : deQ;
  assign effResv  = resvQ | resvSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      eeQ    <= 1'b0;
      ceQ    <= 1'b0;
      deQ    <= 1'b0;
      resvQ  <= 1'b0;
      savedQ <= 1'b0;
      evtQ   <= 1'b0;
    end else begin
      cfgQ  <= cfgEff;
      eeQ   <= effEE    & ~strb.clrExtEn;
      ceQ   <= effCE    & ~strb.clrCritEn;
      deQ   <= effDbgEn & ~strb.clrDbgEn;
      resvQ <= effResv  & ~strb.clrResv;
      evtQ  <= strb.raiseDbgEvt;
      if (strb.zeroSavedDbgEn)  savedQ <= 1'b0;
      else if (strb.saveDbgEn)  savedQ <= effDbgEn;
    end
  end

  assign cfgRdData  = cfgQ;
  assign extEnable  = eeQ;
  assign critEnable = ceQ;
  assign dbgEnable  = deQ;
  assign resvValid  = resvQ;
  assign tbIncEn    = tbTick & cfgQ[IDX_TB_EN];
  assign dbgEvtPend = evtQ;
  assign savedDbgEn = savedQ;

endmodule

// File: rtl/irq_entry_top.sv
module irq_entry_top
  import irq_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        msrWrEn,
  input  logic [2:0]  msrWrData,
  output logic        extEnable,
  output logic        critEnable,
  output logic        dbgEnable,
  input  logic        resvSet,
  output logic        resvValid,
  input  logic        irqExt,
  input  logic        irqCrit,
  input  logic        irqWdog,
  input  logic        irqMchk,
  input  logic        irqDbg,
  input  logic        critDbgEvtEn,
  input  logic        tbTick,
  output logic        tbIncEn,
  output logic        dbgEvtPend,
  output logic        savedDbgEn
);

  policy_t      policy;
  entryStrobe_t strb;
  logic         effDbgEn;

  irq_entry_ctrl u_ctrl (
    .policy       (policy),
    .effDbgEn     (effDbgEn),
    .irqExt       (irqExt),
    .irqCrit      (irqCrit),
    .irqWdog      (irqWdog),
    .irqMchk      (irqMchk),
    .irqDbg       (irqDbg),
    .critDbgEvtEn (critDbgEvtEn),
    .strb         (strb)
  );

  irq_entry_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .cfgRdData  (cfgRdData),
    .msrWrEn    (msrWrEn),
    .msrWrData  (msrWrData),
    .resvSet    (resvSet),
    .tbTick     (tbTick),
    .strb       (strb),
    .policy     (policy),
    .effDbgEn   (effDbgEn),
    .extEnable  (extEnable),
    .critEnable (critEnable),
    .dbgEnable  (dbgEnable),
    .resvValid  (resvValid),
    .tbIncEn    (tbIncEn),
    .dbgEvtPend (dbgEvtPend),
    .savedDbgEn (savedDbgEn)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic clk,
  input logic rstN,
  input logic cfgWrEn,
  input logic msrWrEn,
  input logic swFlag,
  input logic resvClrBit,
  input logic dbgEEBit,
  input logic mchkDEBit,
  input logic extEnable,
  input logic dbgEnable,
  input logic resvValid,
  input logic irqExt,
  input logic irqCrit,
  input logic irqWdog,
  input logic irqMchk,
  input logic irqDbg,
  input logic critDbgEvtEn,
  input logic dbgEvtPend,
  input logic savedDbgEn
);

  logic quiet;
  assign quiet = !cfgWrEn && !msrWrEn;

  // R3: software flag is sticky until reset
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    swFlag |=> swFlag);

  // R5: external-only entry with clear policy drops the reservation
  assert_ext_clears_resv_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqExt && !irqCrit && !irqWdog && !irqMchk && !irqDbg && resvClrBit && quiet)
      |=> !resvValid);

  // R6: debug entry with the external-clear bit drops extEnable
  assert_dbg_clears_ee_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqDbg && !irqMchk && dbgEEBit && quiet) |=> !extEnable);

  // R8: machine check with its clear bit drops dbgEnable
  assert_mchk_clears_de_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqMchk && mchkDEBit && quiet) |=> !dbgEnable);

  // R9: a deferred event needs the event enable and a saved copy of zero
  assert_evt_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgEvtPend) |-> ($past(critDbgEvtEn) && !savedDbgEn));

  // R10: debug entry saves the pre-entry debug enable
  assert_dbg_saves_de_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqDbg && !irqMchk && quiet) |=> (savedDbgEn == $past(dbgEnable)));

endmodule

bind irq_entry_top irq_entry_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWrEn      (cfgWrEn),
  .msrWrEn      (msrWrEn),
  .swFlag       (cfgRdData[16]),
  .resvClrBit   (cfgRdData[17]),
  .dbgEEBit     (cfgRdData[12]),
  .mchkDEBit    (cfgRdData[9]),
  .extEnable    (extEnable),
  .dbgEnable    (dbgEnable),
  .resvValid    (resvValid),
  .irqExt       (irqExt),
  .irqCrit      (irqCrit),
  .irqWdog      (irqWdog),
  .irqMchk      (irqMchk),
  .irqDbg       (irqDbg),
  .critDbgEvtEn (critDbgEvtEn),
  .dbgEvtPend   (dbgEvtPend),
  .savedDbgEn   (savedDbgEn)
);

// File: tb/sim_irq_entry_top.sv
`timescale 1ns/1ps
module sim_irq_entry_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        msrWrEn = 1'b0;
  logic [2:0]  msrWrData = '0;
  logic        extEnable, critEnable, dbgEnable;
  logic        resvSet = 1'b0;
  logic        resvValid;
  logic        irqExt = 1'b0, irqCrit = 1'b0, irqWdog = 1'b0, irqMchk = 1'b0, irqDbg = 1'b0;
  logic        critDbgEvtEn = 1'b0;
  logic        tbTick = 1'b0;
  logic        tbIncEn, dbgEvtPend, savedDbgEn;

  always #10 clk = ~clk;

  irq_entry_top u0 (.*);

  localparam logic [31:0] MASK = 32'h0003_5E00;
  localparam logic [31:0] SWF  = 32'h0001_0000;

  typedef struct {
    logic [38:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;

  // requirement model state
  logic [31:0] mCfg = '0;
  logic mEE = 0, mCE = 0, mDE = 0, mResv = 0, mSaved = 0;

  function automatic logic [38:0] packOut();
    return {cfgRdData, extEnable, critEnable, dbgEnable, resvValid, savedDbgEn, dbgEvtPend, tbIncEn};
  endfunction

  // irq = {mchk, dbg, crit, wdog, ext}
  task automatic step(input logic we, input logic [31:0] wd, input logic me,
                      input logic [2:0] md, input logic rs, input logic [4:0] irq,
                      input logic cde, input logic tk, input string tag);
    exp_t e;
    logic ee, ce, de, pre, resv, evt;
    logic [31:0] cfg;
    @(negedge clk);
    cfgWrEn = we; cfgWrData = wd; msrWrEn = me; msrWrData = md; resvSet = rs;
    {irqMchk, irqDbg, irqCrit, irqWdog, irqExt} = irq;
    critDbgEvtEn = cde; tbTick = tk;
    cfg  = we ? ((wd & MASK) | (mCfg & SWF)) : mCfg;
    ee   = me ? md[2] : mEE;
    ce   = me ? md[1] : mCE;
    de   = me ? md[0] : mDE;
    pre  = de;
    resv = mResv | rs;
    evt  = 1'b0;
    if (irq[4]) begin
      if (cfg[9]) de = 1'b0;
      if (cde && pre) begin evt = 1'b1; mSaved = 1'b0; end
    end else if (irq[3]) begin
      mSaved = pre;
      if (cfg[12]) ee = 1'b0;
      if (cfg[11]) ce = 1'b0;
    end else if (irq[2] || irq[1]) begin
      if (cfg[10]) de = 1'b0;
      if (irq[2] && cfg[17]) resv = 1'b0;
      if (cde && pre) begin evt = 1'b1; mSaved = 1'b0; end
    end else if (irq[0]) begin
      if (cfg[17]) resv = 1'b0;
    end
    mCfg = cfg; mEE = ee; mCE = ce; mDE = de; mResv = resv;
    e.val = {cfg, ee, ce, de, resv, mSaved, evt, tk & cfg[14]};
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after each edge, away from it
  initial begin
    forever begin
      exp_t e;
      logic [38:0] act;
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        act = packOut();
        total++;
        if (act !== e.val) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    total++;
    if (packOut() !== 39'd0) begin
      bad++;
      $display("FAIL R1 actual=%h expected=%h", packOut(), 39'd0);
    end
    @(negedge clk); rstN = 1'b1;

    // R2: only implemented bits stick
    step(1, 32'hFFFF_FFFF, 0, 3'b000, 0, 5'b00000, 0, 0, "R2");
    // R3: writing zero leaves the flag set
    step(1, 32'h0000_0000, 0, 3'b000, 0, 5'b00000, 0, 0, "R3");
    // R4: timebase gate
    step(1, 32'h0000_4000, 0, 3'b000, 0, 5'b00000, 0, 1, "R4");
    step(0, 0, 0, 3'b000, 0, 5'b00000, 0, 0, "R4");
    step(1, 32'h0000_0000, 0, 3'b000, 0, 5'b00000, 0, 1, "R4");
    // R6 / R10: debug entry clears EE and CE, saves DE
    step(1, 32'h0000_1800, 1, 3'b111, 0, 5'b00000, 0, 0, "R6");
    step(0, 0, 0, 3'b000, 0, 5'b01000, 0, 0, "R6");
    step(0, 0, 0, 3'b000, 0, 5'b00000, 0, 0, "R10");
    step(0, 0, 1, 3'b110, 0, 5'b01000, 0, 0, "R10");
    // R12: same-cycle cfg write narrows the debug clear to EE
    step(1, 32'h0000_1000, 1, 3'b111, 0, 5'b01000, 0, 0, "R12");
    // R7: critical and watchdog clear DE, machine check ignores bit 21
    step(1, 32'h0000_0400, 1, 3'b111, 0, 5'b00100, 0, 0, "R7");
    step(0, 0, 1, 3'b111, 0, 5'b00010, 0, 0, "R7");
    step(0, 0, 1, 3'b111, 0, 5'b10000, 0, 0, "R7");
    // R8
    step(1, 32'h0000_0200, 0, 3'b000, 0, 5'b10000, 0, 0, "R8");
    // R5: reservation clearing
    step(1, 32'h0002_0000, 0, 3'b000, 1, 5'b00000, 0, 0, "R5");
    step(0, 0, 0, 3'b000, 0, 5'b00001, 0, 0, "R5");
    step(0, 0, 0, 3'b000, 1, 5'b00000, 0, 0, "R5");
    step(0, 0, 0, 3'b000, 0, 5'b00010, 0, 0, "R5");
    step(0, 0, 0, 3'b000, 0, 5'b10000, 0, 0, "R5");
    step(0, 0, 0, 3'b000, 0, 5'b00100, 0, 0, "R5");
    step(1, 32'h0000_0000, 0, 3'b000, 1, 5'b00000, 0, 0, "R5");
    step(0, 0, 0, 3'b000, 0, 5'b00001, 0, 0, "R5");
    // R12: entry clear beats same-cycle resvSet
    step(1, 32'h0002_0000, 0, 3'b000, 1, 5'b00001, 0, 0, "R12");
    // R9: deferred debug event
    step(0, 0, 1, 3'b111, 0, 5'b01000, 0, 0, "R9");
    step(0, 0, 0, 3'b000, 0, 5'b00100, 1, 0, "R9");
    step(0, 0, 0, 3'b000, 0, 5'b00000, 1, 0, "R9");
    step(0, 0, 1, 3'b110, 0, 5'b00010, 1, 0, "R9");
    step(0, 0, 1, 3'b001, 0, 5'b10000, 0, 0, "R9");
    step(0, 0, 0, 3'b000, 0, 5'b10000, 1, 0, "R9");
    // R11: priority among coincident strobes
    step(1, 32'h0002_1E00, 1, 3'b111, 1, 5'b11111, 0, 0, "R11");
    step(0, 0, 1, 3'b111, 1, 5'b01111, 0, 0, "R11");
    step(0, 0, 1, 3'b111, 1, 5'b00111, 0, 0, "R11");
    step(0, 0, 0, 3'b000, 0, 5'b00000, 0, 0, "R11");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule